// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial memory front end. It gathers the data bytes of one write transaction into a small page latch, then programs them into the memory array in a self-timed cycle that starts on STOP. The front end tells it three things. A transaction has begun, and this strobe carries the word address. A data byte has arrived. A STOP has been seen. A write-protect level decides whether a commit may happen at all.

During the commit the block drives a one-byte memory write port, one slot per clock. It keeps a busy flag high for a fixed number of clocks that stands for the erase/write time. The front end uses this flag to withhold every acknowledge, which lets a host poll for completion. The page size must be a power of two.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: The k-th data byte of a transaction (k counted from 0) lands in page slot (low SW bits of the start address + k) mod PAGE_BYTES. The upper AW-SW address bits stay fixed for the whole transaction. With defaults SW=3 and PAGE_BYTES=8.
- R3: When more than PAGE_BYTES bytes arrive before STOP, the pointer wraps inside the page and the latest byte for a slot replaces the earlier one.
- R4: The memory is written only during a commit. `mem_we` is never high while `busy` is low.
- R5: A STOP that starts a commit raises `busy` on the clock edge where the STOP is sampled. `busy` then stays high for exactly WRITE_CYCLES clocks.
- R6: If `wp` is high when STOP is sampled, nothing is written and `busy` stays low.
- R7: Only slots that received a byte in the current transaction are written. The record of filled slots is cleared at each transaction start.
- R8: A transaction that ends with no data bytes, or that is ended by a new start instead of STOP, writes nothing and leaves `busy` low.
- R9: A commit presents slots in ascending order, one per clock, all within the first PAGE_BYTES clocks of `busy`. The write address is {page upper bits, slot}.
- R10: Start, data and STOP strobes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | One-clock strobe: a write transaction begins |
| txn_addr | input | AW | Word address that goes with `txn_start` |
| byte_vld | input | 1 | One-clock strobe: a data byte has arrived |
| byte_data | input | DW | The data byte |
| stop_seen | input | 1 | One-clock strobe: STOP condition |
| wp | input | 1 | Write protect; high blocks any commit |
| busy | output | 1 | Timed write cycle in progress |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
The assertions assume the three strobes are one-clock pulses that never coincide. They also assume `wp` is stable around a STOP, and that WRITE_CYCLES is at least PAGE_BYTES. The bench drives each strobe as an isolated single-clock pulse from tasks and spaces them by idle clocks. It holds `wp` constant for a whole transaction and keeps the default parameters. The only stimulus that reaches the block during a busy interval is the deliberate R10 traffic, and that traffic also keeps to one strobe per clock.

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int AW           = 8,
  parameter int DW           = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_start,
  input  logic [AW-1:0] txn_addr,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          stop_seen,
  input  logic          wp,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int SW = $clog2(PAGE_BYTES);
  localparam int UW = AW - SW;
  localparam int TW = $clog2(WRITE_CYCLES);

  logic [DW-1:0]         slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] fill_q;
  logic [UW-1:0]         page_q;
  logic [SW-1:0]         ptr_q;
  logic                  open_q;
  logic                  busy_q;
  logic [TW-1:0]         timer_q;
  logic [SW:0]           scan_q;

  wire accept_byte = byte_vld && open_q && !busy_q;
  wire launch      = stop_seen && open_q && !busy_q && |fill_q && !wp;
  wire [SW-1:0] scan_slot = scan_q[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      page_q  <= '0;
      ptr_q   <= '0;
      open_q  <= 1'b0;
      busy_q  <= 1'b0;
      timer_q <= '0;
      scan_q  <= '0;
    end else if (busy_q) begin
      if (!scan_q[SW]) scan_q <= scan_q + 1'b1;
      if (timer_q == TW'(WRITE_CYCLES - 1)) busy_q <= 1'b0;
      else timer_q <= timer_q + 1'b1;
    end else if (txn_start) begin
      page_q <= txn_addr[AW-1:SW];
      ptr_q  <= txn_addr[SW-1:0];
      fill_q <= '0;
      open_q <= 1'b1;
    end else if (stop_seen) begin
      open_q  <= 1'b0;
      busy_q  <= launch;
      timer_q <= '0;
      scan_q  <= '0;
    end else if (accept_byte) begin
      fill_q[ptr_q] <= 1'b1;
      ptr_q         <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_byte && !txn_start && !stop_seen) slot_q[ptr_q] <= byte_data;
  end

  assign busy      = busy_q;
  assign mem_we    = busy_q && !scan_q[SW] && fill_q[scan_slot];
  assign mem_addr  = {page_q, scan_slot};
  assign mem_wdata = slot_q[scan_slot];
endmodule

module page_commit_buf_chk #(
  parameter int AW           = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_seen,
  input logic          wp,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  localparam int SW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WRITE_CYCLES + 1) + 1;

  logic [CW-1:0] busy_len;
  logic [CW-1:0] we_pos;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
      we_pos   <= '0;
    end else begin
      busy_len <= busy ? busy_len + 1'b1 : '0;
      we_pos   <= busy ? we_pos + 1'b1 : '0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!busy && !mem_we));
  // R4
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);
  // R5
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(stop_seen));
  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> busy_len == CW'(WRITE_CYCLES));
  // R5
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> busy_len < CW'(WRITE_CYCLES));
  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (stop_seen && wp && !busy) |=> !busy);
  // R9
  write_window_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> we_pos < CW'(PAGE_BYTES));
  // R9
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(busy) && busy) |-> (mem_addr[SW-1:0] == SW'(we_pos)));
endmodule

bind page_commit_buf page_commit_buf_chk #(
  .AW(AW), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_seen(stop_seen), .wp(wp),
  .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/page_commit_buf_bench.sv
module page_commit_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PB = 8;
  localparam int WC = 64;
  localparam int MEMSZ = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic txn_start = 0, byte_vld = 0, stop_seen = 0, wp = 0;
  logic [AW-1:0] txn_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  page_commit_buf #(.AW(AW), .DW(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u_page_commit_buf (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_seen(stop_seen), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] cap [MEMSZ];
  logic [DW-1:0] ref_mem [MEMSZ];
  int wr_count, busy_cycles, late_writes, order_errs, last_low;

  always @(negedge clk) begin
    if (busy) busy_cycles++;
    if (mem_we) begin
      cap[mem_addr] = mem_wdata;
      wr_count++;
      if (busy_cycles > PB) late_writes++;
      if (int'(mem_addr[2:0]) <= last_low) order_errs++;
      last_low = int'(mem_addr[2:0]);
    end
    if (!busy) last_low = -1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    txn_addr = a; txn_start = 1; @(negedge clk); txn_start = 0; @(negedge clk);
  endtask
  task automatic pulse_byte(input logic [DW-1:0] d);
    byte_data = d; byte_vld = 1; @(negedge clk); byte_vld = 0;
  endtask
  task automatic pulse_stop();
    stop_seen = 1; @(negedge clk); stop_seen = 0;
  endtask

  function automatic int popcnt(input logic [PB-1:0] v);
    int c = 0;
    for (int i = 0; i < PB; i++) c += int'(v[i]);
    return c;
  endfunction

  // end_kind: 0 = STOP, 1 = restart (new start, then bare STOP)
  task automatic run_txn(input logic [AW-1:0] a, input int n, input bit wpv, input int end_kind,
                         input bit poke_busy);
    logic [DW-1:0] page [PB];
    logic [PB-1:0] vmask = '0;
    int slot;
    bit commit;
    wr_count = 0; busy_cycles = 0; late_writes = 0; order_errs = 0;
    wp = wpv;
    pulse_start(a);
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] d = DW'($urandom);
      slot = (int'(a[2:0]) + k) % PB;
      page[slot] = d; vmask[slot] = 1'b1;
      pulse_byte(d);
    end
    commit = (end_kind == 0) && (n > 0) && !wpv;
    if (end_kind == 1) begin
      pulse_start(a ^ 8'h08);
      pulse_stop();
      check(!busy, "R8 restart", int'(busy), 0);
    end else begin
      pulse_stop();
      check(busy == commit, commit ? "R5 rise" : (wpv ? "R6 wp" : "R8 empty"), int'(busy), int'(commit));
    end
    if (poke_busy && busy) begin
      pulse_start(a); pulse_byte(8'h5A); pulse_byte(8'hA5); pulse_stop();
    end
    repeat (WC + 6) @(negedge clk);
    if (commit)
      for (int i = 0; i < PB; i++)
        if (vmask[i]) ref_mem[{a[AW-1:3], 3'(i)}] = page[i];
    check(busy_cycles == (commit ? WC : 0), "R5 length", busy_cycles, commit ? WC : 0);
    check(wr_count == (commit ? popcnt(vmask) : 0), "R7 slots written", wr_count,
          commit ? popcnt(vmask) : 0);
    check(late_writes == 0 && order_errs == 0, "R9 order", late_writes + order_errs, 0);
    for (int i = 0; i < PB; i++) begin
      logic [AW-1:0] ad = {a[AW-1:3], 3'(i)};
      check(cap[ad] == ref_mem[ad], "R2 R3 R4 R10 content", int'(cap[ad]), int'(ref_mem[ad]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMSZ; i++) begin cap[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    check(!busy && !mem_we, "R1 reset", int'(busy) + int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !mem_we, "R1 after release", int'(busy) + int'(mem_we), 0);
    run_txn(8'h10, 1, 0, 0, 0);   // R2 single byte
    run_txn(8'h23, 8, 0, 0, 0);   // R2 full page from mid address
    run_txn(8'h47, 11, 0, 0, 0);  // R3 wrap and overwrite
    run_txn(8'h61, 3, 0, 0, 0);   // R7 partial page
    run_txn(8'h61, 2, 0, 0, 0);   // R7 mask cleared; prior bytes stay
    run_txn(8'h80, 5, 1, 0, 0);   // R6 write protected
    run_txn(8'h90, 0, 0, 0, 0);   // R8 no data
    run_txn(8'hA4, 4, 0, 1, 0);   // R8 repeated start
    run_txn(8'hC2, 6, 0, 0, 1);   // R10 strobes during busy
    for (int t = 0; t < 30; t++)
      run_txn(AW'($urandom), int'($urandom_range(0, 17)), bit'($urandom_range(0, 4) == 0),
              int'($urandom_range(0, 5) == 0), bit'($urandom_range(0, 1)));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule